// File: doc/BRIEF.md
# Flow-Controlled Serial Transmit Channel

This block is one transmit channel of an asynchronous serial port. The CPU side writes bytes into an eight-entry queue. A framing state machine takes them one at a time and sends each as a frame on a single line: a low start bit, the data bits with the least significant first, an optional parity bit and one or two high stop bits. Bit timing comes from an external one-cycle tick. One bit lasts sixteen ticks, and every change on the line falls on a tick.

Flow control works at the edges of a message. With clear-to-send gating on, a character may begin only while the active-low CTS input is low. A character already on the line always completes. With automatic request-to-send on, the RTS output that software raised is dropped once the transmitter has been disabled, the queue is empty and the line is idle. A break command holds the line low until a stop-break or a transmitter reset. A break waits behind characters that are ready to go, but it starts at once when those characters are held back by CTS or by the channel being disabled. An interrupt output reports that enough queue entries are free.

The framing machine has six states. IDLE holds the line high. START sends the low start bit. DATA shifts the data bits out. PARITY sends the parity bit. STOP sends one or two high bits. BREAK holds the line low. Its transitions are:
- IDLE to START on a tick when a character may be sent.
- IDLE to BREAK on a tick when a break is pending and no character may be sent.
- START to DATA at the end of the bit.
- DATA to PARITY, or to STOP when there is no parity, after the last data bit.
- PARITY to STOP.
- STOP to IDLE after the last stop bit.
- BREAK to IDLE on stop-break.
- Any state to IDLE on transmitter reset.

Top module: `uart_tx_flow`

## Requirements
- R1: A frame starts with one low bit and then carries `mode_len`+5 data bits (encoding 0..3 gives 5..8 bits), least significant bit first. Each bit lasts 16 ticks of `baud_tick`, and a frame begins only on a tick.
- R2: `mode_parity` 1 adds an even-parity bit after the data bits and 2 adds an odd-parity bit. The parity covers only the data bits that are sent. Values 0 and 3 send no parity bit.
- R3: A frame ends with one high stop bit, or with two when `mode_stop2` is 1. The mode fields are captured when a character is taken from the queue.
- R4: After reset the channel is disabled, `txd` is 1, `rts_n` is 1, and the queue is empty. With the queue empty the line holds 1 between frames.
- R5: `cmd_disable` lets the character already being sent finish. Queued bytes are kept and are sent after a later `cmd_enable`.
- R6: With `mode_auto_rts` set, an RTS raised by `rts_on` drops (`rts_n` becomes 1) when the channel is disabled, the queue is empty and the line is idle.
- R7: With `mode_auto_rts` set, writes made while the channel is disabled are discarded.
- R8: With `mode_auto_cts` set, a character starts only while `cts_n` is 0. If `cts_n` rises during a character, that character completes and the line then stays at 1.
- R9: `cmd_brk_start` drives `txd` to 0 continuously, regardless of CTS. The break waits while a character can be sent. It begins on the next tick when nothing can be sent, including when CTS holds queued data back.
- R10: A break ends only on `cmd_brk_stop` or `cmd_reset`, and `txd` returns to 1 on the following cycle. `cmd_reset` also disables the channel and empties the queue.
- R11: `fifo_irq` is 1 while the number of free queue entries is at least 2^`irq_sel` (1, 2, 4 or 8).
- R12: The queue holds 8 bytes. A write to a full queue is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe into the queue |
| wr_data | input | 8 | Byte to queue |
| cmd_enable | input | 1 | Enable transmission (one-cycle pulse) |
| cmd_disable | input | 1 | Disable after the current character |
| cmd_reset | input | 1 | Transmitter reset: abort, flush, disable, end break |
| cmd_brk_start | input | 1 | Request a break |
| cmd_brk_stop | input | 1 | End or cancel a break |
| mode_len | input | 2 | Data length, 0..3 means 5..8 bits |
| mode_parity | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| mode_stop2 | input | 1 | Two stop bits when 1 |
| mode_auto_rts | input | 1 | Automatic RTS drop at end of message |
| mode_auto_cts | input | 1 | Gate character starts on CTS |
| irq_sel | input | 2 | Free-entry threshold select |
| baud_tick | input | 1 | One-cycle tick, 16 per bit |
| rts_on | input | 1 | Software asserts RTS |
| rts_off | input | 1 | Software negates RTS |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial output |
| rts_n | output | 1 | Request-to-send, active low |
| fifo_irq | output | 1 | Free-space interrupt |

## Verification
Frames are sent in four shapes: 8 bits with no parity and one stop bit, 5 bits with even parity and two stop bits, 7 bits with odd parity, and a full queue of eight mixed bytes. Together they separate errors in bit order, data length, parity sense and stop count. A monitor decodes every frame at mid-bit and checks it against a queue filled as bytes are written, so a lost, extra or reordered byte shows up. Disable and CTS negation are each applied in the middle of a character: exactly one more frame must appear, and the rest must appear only after release. Break is applied three ways: on an idle line, behind a sendable byte, and behind a CTS-blocked byte. These show whether the deferral rule and the end-of-break paths are correct.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;
    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP, TX_BREAK
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_OFF = 2'd3
    } par_e;

    typedef struct packed {
        logic [1:0] len;
        par_e       par;
        logic       stop2;
    } frame_cfg_t;
endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push_req,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                rdata,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push;

    assign push  = push_req && !full;
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign level = cnt;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // R12
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !clr) |=> full);

    // R12
    fifo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/txf_framer.sv
module txf_framer
    import uart_txf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TICKS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          abort,
    input  logic          start_char,
    input  logic          start_brk,
    input  logic          brk_end,
    input  logic [DW-1:0] char_in,
    input  frame_cfg_t    cfg_in,
    output logic          take,
    output logic          txd,
    output logic          idle,
    output logic          in_break
);
    localparam int TW = $clog2(TICKS);
    localparam int IW = $clog2(DW);

    tx_state_e     state_q, state_d;
    logic [TW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;
    logic [DW-1:0] shreg;
    logic [DW-1:0] load_mask;
    frame_cfg_t    cfg_q;
    logic          par_q, par_calc, has_par, bit_end;

    assign bit_end   = tick && (cnt == TW'(TICKS - 1));
    assign last_idx  = IW'(DW - 4) + IW'(cfg_q.len);
    assign has_par   = (cfg_q.par == PAR_EVEN) || (cfg_q.par == PAR_ODD);
    assign load_mask = ~({DW{1'b1}} << (DW - 3 + int'(cfg_in.len)));
    assign par_calc  = (^(char_in & load_mask)) ^ (cfg_in.par == PAR_ODD);
    assign take      = (state_q == TX_IDLE) && tick && start_char && !abort;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (tick && start_char)     state_d = TX_START;
                       else if (tick && start_brk) state_d = TX_BREAK;
            TX_START:  if (bit_end) state_d = TX_DATA;
            TX_DATA:   if (bit_end && idx == last_idx)
                           state_d = has_par ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) state_d = TX_STOP;
            TX_STOP:   if (bit_end && (!cfg_q.stop2 || idx == IW'(1)))
                           state_d = TX_IDLE;
            TX_BREAK:  if (brk_end) state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
        if (abort) state_d = TX_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // bit timing and shift datapath
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            par_q <= 1'b0;
            cfg_q <= '0;
        end else if (take) begin
            shreg <= char_in;
            cfg_q <= cfg_in;
            par_q <= par_calc;
            cnt   <= '0;
            idx   <= '0;
        end else if (tick && state_q != TX_IDLE && state_q != TX_BREAK) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
            if (bit_end) begin
                unique case (state_q)
                    TX_DATA: begin
                        shreg <= shreg >> 1;
                        idx   <= (idx == last_idx) ? '0 : idx + 1'b1;
                    end
                    TX_STOP: idx <= idx + 1'b1;
                    default: idx <= '0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        txd      = 1'b1;
        idle     = 1'b0;
        in_break = 1'b0;
        unique case (state_q)
            TX_IDLE:   idle = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_q;
            TX_STOP:   txd = 1'b1;
            TX_BREAK: begin
                txd      = 1'b0;
                in_break = 1'b1;
            end
            default:   txd = 1'b1;
        endcase
    end

    // R1
    data_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA) |-> (idx <= last_idx));

    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_START && $past(state_q) == TX_IDLE) |-> $past(start_char && tick));

    // R10
    break_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_BREAK && !brk_end && !abort) |=> (state_q == TX_BREAK));
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
    import uart_txf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int TICKS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          cmd_enable,
    input  logic          cmd_disable,
    input  logic          cmd_reset,
    input  logic          cmd_brk_start,
    input  logic          cmd_brk_stop,
    input  logic [1:0]    mode_len,
    input  logic [1:0]    mode_parity,
    input  logic          mode_stop2,
    input  logic          mode_auto_rts,
    input  logic          mode_auto_cts,
    input  logic [1:0]    irq_sel,
    input  logic          baud_tick,
    input  logic          rts_on,
    input  logic          rts_off,
    input  logic          cts_n,
    output logic          txd,
    output logic          rts_n,
    output logic          fifo_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          en_q, brk_pend_q, rts_q, drop_cond_q;
    logic          empty, full, take, idle, in_break;
    logic          cts_ok, start_char, start_brk, wr_ok, drop_cond;
    logic [DW-1:0] head;
    logic [CW-1:0] level, free_w;
    frame_cfg_t    cfg;

    assign cfg        = '{len: mode_len, par: par_e'(mode_parity), stop2: mode_stop2};
    assign cts_ok     = !mode_auto_cts || !cts_n;
    assign start_char = en_q && !empty && cts_ok;
    assign start_brk  = brk_pend_q && !start_char;
    assign wr_ok      = wr_en && !(mode_auto_rts && !en_q);
    assign drop_cond  = mode_auto_rts && !en_q && empty && idle;
    assign free_w     = CW'(DEPTH) - level;
    assign fifo_irq   = free_w >= (CW'(1) << irq_sel);
    assign rts_n      = !rts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            brk_pend_q  <= 1'b0;
            rts_q       <= 1'b0;
            drop_cond_q <= 1'b1;
        end else begin
            if (cmd_reset || cmd_disable) en_q <= 1'b0;
            else if (cmd_enable)          en_q <= 1'b1;
            if (cmd_reset || cmd_brk_stop || in_break) brk_pend_q <= 1'b0;
            else if (cmd_brk_start)                    brk_pend_q <= 1'b1;
            if (rts_off || (drop_cond && !drop_cond_q)) rts_q <= 1'b0;
            else if (rts_on)                            rts_q <= 1'b1;
            drop_cond_q <= drop_cond;
        end
    end

    txf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(cmd_reset), .push_req(wr_ok),
        .wdata(wr_data), .pop(take), .rdata(head), .empty(empty),
        .full(full), .level(level)
    );

    txf_framer #(.DW(DW), .TICKS(TICKS)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .abort(cmd_reset),
        .start_char(start_char), .start_brk(start_brk), .brk_end(cmd_brk_stop),
        .char_in(head), .cfg_in(cfg), .take(take), .txd(txd), .idle(idle),
        .in_break(in_break)
    );

    // R6
    rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cond && !drop_cond_q && !rts_on) |=> rts_n);

    // R7
    auto_rts_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_auto_rts && !en_q && !take && !cmd_reset) |=> (level <= $past(level)));
endmodule

// File: tb/uart_tx_flow_test.sv
module uart_tx_flow_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, cmd_enable = 0, cmd_disable = 0, cmd_reset = 0;
    logic cmd_brk_start = 0, cmd_brk_stop = 0;
    logic [7:0] wr_data = '0;
    logic [1:0] mode_len = 2'd3, mode_parity = 2'd0, irq_sel = 2'd0;
    logic mode_stop2 = 0, mode_auto_rts = 0, mode_auto_cts = 0;
    logic rts_on = 0, rts_off = 0, cts_n = 1'b0;
    logic baud_tick = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic txd, rts_n, fifo_irq;

    int nchk = 0, nerr = 0, frames_done = 0;
    bit mon_on = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic [1:0] len;
        logic [1:0] par;
        logic       s2;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
    end

    uart_tx_flow uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
        .cmd_brk_start(cmd_brk_start), .cmd_brk_stop(cmd_brk_stop),
        .mode_len(mode_len), .mode_parity(mode_parity), .mode_stop2(mode_stop2),
        .mode_auto_rts(mode_auto_rts), .mode_auto_cts(mode_auto_cts),
        .irq_sel(irq_sel), .baud_tick(baud_tick), .rts_on(rts_on),
        .rts_off(rts_off), .cts_n(cts_n), .txd(txd), .rts_n(rts_n),
        .fifo_irq(fifo_irq)
    );

    task automatic check(input bit c, input string tag, input int act, input int exp);
        nchk++;
        if (!c) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!baud_tick);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: cmd_enable = 1;
            1: cmd_disable = 1;
            2: cmd_reset = 1;
            3: cmd_brk_start = 1;
            4: cmd_brk_stop = 1;
            default: rts_on = 1;
        endcase
        @(negedge clk);
        {cmd_enable, cmd_disable, cmd_reset, cmd_brk_start, cmd_brk_stop, rts_on} = '0;
    endtask

    task automatic send(input logic [7:0] b, input bit expected);
        exp_t e;
        @(negedge clk);
        wr_en = 1;
        wr_data = b;
        if (expected) begin
            e.d = b; e.len = mode_len; e.par = mode_parity; e.s2 = mode_stop2;
            sb.push_back(e);
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_start();
        do @(negedge clk); while (txd !== 1'b0);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        wait_ticks(16 * 13);
    endtask

    // monitor: decodes frames at mid-bit and compares with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && rst_n && txd === 1'b0) begin
                exp_t e;
                logic [7:0] got, want, mask;
                logic st, pb, s1, s2b, pexp;
                int nb;
                wait_ticks(8);
                st = txd;
                if (sb.size() == 0) begin
                    check(0, "R4 unexpected frame", 1, 0);
                    wait_ticks(16 * 12);
                end else begin
                    e = sb.pop_front();
                    nb = 5 + int'(e.len);
                    got = '0;
                    for (int i = 0; i < nb; i++) begin
                        wait_ticks(16);
                        got[i] = txd;
                    end
                    mask = 8'hFF >> (8 - nb);
                    want = e.d & mask;
                    pb = 1'b0; pexp = 1'b0;
                    if (e.par == 2'd1 || e.par == 2'd2) begin
                        wait_ticks(16);
                        pb = txd;
                        pexp = (^want) ^ (e.par == 2'd2);
                    end
                    wait_ticks(16);
                    s1 = txd;
                    s2b = 1'b1;
                    if (e.s2) begin
                        wait_ticks(16);
                        s2b = txd;
                    end
                    // R1 R2 R3 frame content
                    check(st == 0 && got == want && pb == pexp && s1 && s2b,
                          "R1 R2 R3 frame", {st, pb, s1, s2b, got}, {4'b0, pexp, 2'b11, want});
                    frames_done++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", frames_done, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R4 reset state
        check(txd == 1, "R4 txd after reset", txd, 1);
        check(rts_n == 1, "R4 rts_n after reset", rts_n, 1);
        check(fifo_irq == 1, "R11 irq with empty queue", fifo_irq, 1);

        mon_on = 1;
        pulse(0);
        mode_len = 2'd3; mode_parity = 2'd0; mode_stop2 = 0;
        send(8'hA5, 1); send(8'h3C, 1);
        drain();
        check(txd == 1, "R4 idle mark", txd, 1);

        mode_len = 2'd0; mode_parity = 2'd1; mode_stop2 = 1;
        send(8'h1F, 1); send(8'h12, 1);
        drain();
        mode_len = 2'd2; mode_parity = 2'd2; mode_stop2 = 0;
        send(8'h55, 1); send(8'hE0, 1);
        drain();

        // R11 / R12: fill while disabled
        mode_len = 2'd3; mode_parity = 2'd0;
        pulse(1);
        f0 = frames_done;
        for (int i = 0; i < 6; i++) send(8'(8'h10 + i * 7), 1);
        irq_sel = 2'd1; @(negedge clk);
        check(fifo_irq == 1, "R11 free 2 thr 2", fifo_irq, 1);
        irq_sel = 2'd2; @(negedge clk);
        check(fifo_irq == 0, "R11 free 2 thr 4", fifo_irq, 0);
        send(8'h77, 1); send(8'h88, 1);
        irq_sel = 2'd0; @(negedge clk);
        check(fifo_irq == 0, "R11 full thr 1", fifo_irq, 0);
        send(8'hEE, 0);
        pulse(0);
        drain();
        wait_ticks(16 * 13);
        check(frames_done == f0 + 8, "R12 eight frames only", frames_done - f0, 8);
        irq_sel = 2'd3; @(negedge clk);
        check(fifo_irq == 1, "R11 free 8 thr 8", fifo_irq, 1);

        // R5 disable mid-character
        f0 = frames_done;
        send(8'h81, 1); send(8'h42, 1); send(8'h99, 1);
        wait_start();
        pulse(1);
        wait_ticks(16 * 25);
        check(frames_done == f0 + 1 && txd == 1, "R5 only current char", frames_done - f0, 1);
        pulse(0);
        drain();
        check(frames_done == f0 + 3, "R5 queued sent after enable", frames_done - f0, 3);

        // R6 / R7 auto-RTS
        mode_auto_rts = 1;
        pulse(1);
        pulse(5);
        check(rts_n == 0, "R6 rts asserted by software", rts_n, 0);
        pulse(0);
        send(8'h6E, 1);
        wait_start();
        pulse(1);
        check(rts_n == 0, "R6 rts held mid-frame", rts_n, 0);
        drain();
        check(rts_n == 1, "R6 rts dropped at end", rts_n, 1);
        f0 = frames_done;
        send(8'h11, 0);
        pulse(0);
        wait_ticks(16 * 13);
        check(frames_done == f0, "R7 write refused while disabled", frames_done - f0, 0);
        mode_auto_rts = 0;

        // R8 auto-CTS
        mode_auto_cts = 1;
        cts_n = 1;
        f0 = frames_done;
        send(8'h5A, 1);
        wait_ticks(16 * 30);
        check(frames_done == f0 && txd == 1, "R8 blocked by cts", frames_done - f0, 0);
        cts_n = 0;
        drain();
        check(frames_done == f0 + 1, "R8 sent after cts", frames_done - f0, 1);
        f0 = frames_done;
        send(8'hC3, 1); send(8'h3C, 1);
        wait_start();
        cts_n = 1;
        wait_ticks(16 * 25);
        check(frames_done == f0 + 1 && txd == 1, "R8 char completes then holds", frames_done - f0, 1);
        cts_n = 0;
        drain();
        check(frames_done == f0 + 2, "R8 resumed", frames_done - f0, 2);

        // R9 / R10 break
        mon_on = 0;
        mode_len = 2'd3; mode_parity = 2'd0; mode_stop2 = 0;
        cts_n = 1;
        pulse(3);
        wait_ticks(2);
        check(txd == 0, "R9 break on idle ignores cts", txd, 0);
        wait_ticks(64);
        check(txd == 0, "R9 break continuous", txd, 0);
        pulse(4);
        check(txd == 1, "R10 stop-break ends break", txd, 1);

        cts_n = 0;
        send(8'hFF, 0);
        wait_start();
        pulse(3);
        wait_ticks(24);
        check(txd == 1, "R9 break deferred behind data", txd, 1);
        wait_ticks(16 * 10);
        check(txd == 0, "R9 break after frame", txd, 0);
        pulse(4);
        check(txd == 1, "R10 stop-break after deferred break", txd, 1);

        cts_n = 1;
        send(8'h0F, 0);
        wait_ticks(32);
        check(txd == 1, "R8 byte held by cts", txd, 1);
        pulse(3);
        wait_ticks(2);
        check(txd == 0, "R9 break when cts blocks data", txd, 0);
        pulse(2);
        check(txd == 1, "R10 reset ends break", txd, 1);
        cts_n = 0;
        pulse(0);
        begin
            bit all_high = 1'b1;
            for (int i = 0; i < 26; i++) begin
                wait_ticks(8);
                if (txd != 1) all_high = 1'b0;
            end
            check(all_high, "R10 reset flushed queue", all_high, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule